// File: doc/BRIEF.md
# Ones-Complement Accumulator ALU

This block is the accumulator half of a 36-bit word machine's arithmetic path. A sequencer outside the block presents a six-bit operation code together with a 36-bit operand word, which is normally the word just read from memory, and pulses a start strobe. One clock later the block has updated its registered outputs and raises a one-cycle done pulse. The outputs are the accumulator, a sticky overflow flag, a skip indication and a merged word that is ready to be written back to memory.

Signed values use the ones-complement form. The sign is the most significant vector bit. A negative number is the bitwise inverse of its magnitude. Addition folds the carry out of the top bit back into the bottom bit. Subtraction adds the inverted operand, so the result can be negative zero. There are two partial-store operations. Each builds a write-back word that takes one half from the accumulator and the other half from the operand, which stands for the old memory word. The split is at vector bit 18.

Top module: `ocacc_alu`

## Requirements
- R1: While reset is asserted (rst_n low), and right after it, acc_o, merge_o, ovf_o, skip_o and done_o are all zero.
- R2: A start_i pulse makes done_o high in the next cycle only. When start_i is low, acc_o, merge_o and skip_o keep their values and done_o is low.
- R3: Opcode 6'o40 (add) loads acc_o with acc + operand in ones-complement. The carry out of bit 35 is added back into bit 0.
- R4: Opcode 6'o42 (subtract) loads acc_o with acc + ~operand. Subtracting a value equal to the accumulator gives all ones (negative zero).
- R5: ovf_o is set by an add or a subtract whose two addends (for subtract, acc and ~operand) have equal bit 35 while the result's bit 35 differs. ovf_o stays set until a cycle with ovf_clr_i high clears it. If the clear and a new overflow happen in the same cycle, the flag ends set.
- R6: Opcodes 6'o02, 6'o04 and 6'o06 load acc_o with the bitwise AND, inclusive OR and exclusive OR, respectively, of the accumulator and the operand. ovf_o is unaffected.
- R7: Opcode 6'o20 loads acc_o with the operand. ovf_o is unaffected.
- R8: Opcode 6'o50 sets skip_o exactly when the accumulator and the operand differ in any bit, so +0 and -0 count as different. Every other started operation clears skip_o.
- R9: Opcode 6'o26 sets merge_o to {operand[35:18], acc[17:0]} and leaves acc_o unchanged.
- R10: Opcode 6'o30 sets merge_o to {acc[35:18], operand[17:0]} and leaves acc_o unchanged.
- R11: Any other opcode leaves acc_o, merge_o and ovf_o unchanged, clears skip_o, and still pulses done_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Starts the operation selected by opcode_i |
| opcode_i | input | 6 | Operation code |
| operand_i | input | 36 | Operand word / old memory word |
| ovf_clr_i | input | 1 | Clears the sticky overflow flag |
| acc_o | output | 36 | Accumulator |
| ovf_o | output | 1 | Sticky overflow flag |
| skip_o | output | 1 | Skip indication from the compare operation |
| merge_o | output | 36 | Merged word for partial-store write-back |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The bench aims at end-around carry with sums such as 5 + (-3). An adder that drops the carry would give 1 instead of 2. It also checks subtraction of equal values, which must give negative zero; a two's-complement design would return all zeros here. Both signs of overflow are covered, along with stickiness across later loads and the case where a clear and a new overflow arrive in the same cycle. A flag that is not sticky, or that lets the clear win, shows a wrong ovf_o. The compare of +0 against -0 catches a compare that goes by value rather than by bits. The two partial stores catch swapped halves. An unused opcode catches a decoder that falls through into one of the real operations.

// File: rtl/ocacc_pkg.sv
package ocacc_pkg;

    localparam int WORD_W  = 36;
    localparam int LOW_W   = 18;
    localparam int OPC_W   = 6;

    localparam logic [OPC_W-1:0] OPC_AND = 6'o02;
    localparam logic [OPC_W-1:0] OPC_IOR = 6'o04;
    localparam logic [OPC_W-1:0] OPC_XOR = 6'o06;
    localparam logic [OPC_W-1:0] OPC_LAC = 6'o20;
    localparam logic [OPC_W-1:0] OPC_DAP = 6'o26;
    localparam logic [OPC_W-1:0] OPC_DIP = 6'o30;
    localparam logic [OPC_W-1:0] OPC_ADD = 6'o40;
    localparam logic [OPC_W-1:0] OPC_SUB = 6'o42;
    localparam logic [OPC_W-1:0] OPC_SAD = 6'o50;

    typedef enum logic [1:0] {
        LOP_AND = 2'd0,
        LOP_IOR = 2'd1,
        LOP_XOR = 2'd2
    } lop_e;

    typedef struct packed {
        logic [WORD_W-1:0] acc;
        logic [WORD_W-1:0] merge;
        logic              ovf;
        logic              skip;
        logic              done;
    } acc_state_t;

endpackage

// File: rtl/ocacc_oc_adder.sv
module ocacc_oc_adder #(
    parameter int W = 36
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] sum_o,
    output logic         ovf_o
);
    localparam int SIGN = W - 1;

    logic [W:0]   raw;
    logic [W-1:0] wrap;

    always_comb begin
        raw   = {1'b0, a_i} + {1'b0, b_i};
        wrap  = raw[W-1:0] + {{(W-1){1'b0}}, raw[W]};
        sum_o = wrap;
        ovf_o = (a_i[SIGN] == b_i[SIGN]) && (wrap[SIGN] != a_i[SIGN]);
    end

endmodule

// File: rtl/ocacc_bitwise.sv
module ocacc_bitwise
    import ocacc_pkg::*;
#(
    parameter int W = 36
) (
    input  lop_e         sel_i,
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] y_o
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        always_comb begin
            case (sel_i)
                LOP_AND: y_o[i] = a_i[i] & b_i[i];
                LOP_IOR: y_o[i] = a_i[i] | b_i[i];
                LOP_XOR: y_o[i] = a_i[i] ^ b_i[i];
                default: y_o[i] = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/ocacc_half_merge.sv
module ocacc_half_merge #(
    parameter int W         = 36,
    parameter int LOW_W     = 18,
    parameter bit ACC_HIGH  = 1'b0
) (
    input  logic [W-1:0] acc_i,
    input  logic [W-1:0] mem_i,
    output logic [W-1:0] y_o
);
    localparam int HIGH_W = W - LOW_W;

    if (ACC_HIGH) begin : g_acc_high
        assign y_o = {acc_i[W-1:LOW_W], mem_i[LOW_W-1:0]};
    end else begin : g_acc_low
        assign y_o = {mem_i[W-1:W-HIGH_W], acc_i[LOW_W-1:0]};
    end

endmodule

// File: rtl/ocacc_alu.sv
module ocacc_alu
    import ocacc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [OPC_W-1:0]  opcode_i,
    input  logic [WORD_W-1:0] operand_i,
    input  logic              ovf_clr_i,
    output logic [WORD_W-1:0] acc_o,
    output logic              ovf_o,
    output logic              skip_o,
    output logic [WORD_W-1:0] merge_o,
    output logic              done_o
);
    acc_state_t        st_d, st_q;
    logic [WORD_W-1:0] addend_b;
    logic [WORD_W-1:0] sum_w;
    logic              sum_ovf;
    lop_e              lop_sel;
    logic [WORD_W-1:0] lop_y;
    logic [WORD_W-1:0] dap_y;
    logic [WORD_W-1:0] dip_y;

    assign addend_b = (opcode_i == OPC_SUB) ? ~operand_i : operand_i;

    ocacc_oc_adder #(.W(WORD_W)) u_add (
        .a_i   (st_q.acc),
        .b_i   (addend_b),
        .sum_o (sum_w),
        .ovf_o (sum_ovf)
    );

    always_comb begin
        case (opcode_i)
            OPC_IOR: lop_sel = LOP_IOR;
            OPC_XOR: lop_sel = LOP_XOR;
            default: lop_sel = LOP_AND;
        endcase
    end

    ocacc_bitwise #(.W(WORD_W)) u_lop (
        .sel_i (lop_sel),
        .a_i   (st_q.acc),
        .b_i   (operand_i),
        .y_o   (lop_y)
    );

    ocacc_half_merge #(.W(WORD_W), .LOW_W(LOW_W), .ACC_HIGH(1'b0)) u_dap (
        .acc_i (st_q.acc),
        .mem_i (operand_i),
        .y_o   (dap_y)
    );

    ocacc_half_merge #(.W(WORD_W), .LOW_W(LOW_W), .ACC_HIGH(1'b1)) u_dip (
        .acc_i (st_q.acc),
        .mem_i (operand_i),
        .y_o   (dip_y)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (ovf_clr_i) begin
            st_d.ovf = 1'b0;
        end
        if (start_i) begin
            st_d.done = 1'b1;
            st_d.skip = 1'b0;
            case (opcode_i)
                OPC_ADD, OPC_SUB: begin
                    st_d.acc = sum_w;
                    if (sum_ovf) begin
                        st_d.ovf = 1'b1;
                    end
                end
                OPC_AND, OPC_IOR, OPC_XOR: st_d.acc = lop_y;
                OPC_LAC: st_d.acc   = operand_i;
                OPC_DAP: st_d.merge = dap_y;
                OPC_DIP: st_d.merge = dip_y;
                OPC_SAD: st_d.skip  = |(st_q.acc ^ operand_i);
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign acc_o   = st_q.acc;
    assign ovf_o   = st_q.ovf;
    assign skip_o  = st_q.skip;
    assign merge_o = st_q.merge;
    assign done_o  = st_q.done;

endmodule

// File: rtl/ocacc_alu_chk.sv
module ocacc_alu_chk #(
    parameter int W     = 36,
    parameter int LOW_W = 18
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start_i,
    input logic [5:0]   opcode_i,
    input logic [W-1:0] operand_i,
    input logic         ovf_clr_i,
    input logic [W-1:0] acc_o,
    input logic         ovf_o,
    input logic         skip_o,
    input logic [W-1:0] merge_o,
    input logic         done_o
);
    p_done_after_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> done_o);

    p_no_done_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !start_i |=> !done_o);

    p_acc_hold_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !start_i |=> $stable(acc_o) && $stable(merge_o) && $stable(skip_o));

    p_ovf_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_o && !ovf_clr_i |=> ovf_o);

    p_ovf_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_clr_i && !start_i |=> !ovf_o);

    p_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
        start_i && opcode_i == 6'o20 |=> acc_o == $past(operand_i));

    p_skip_origin_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(skip_o) |-> $past(start_i) && $past(opcode_i) == 6'o50);

    p_dap_merge_r9: assert property (@(posedge clk) disable iff (!rst_n)
        start_i && opcode_i == 6'o26 |=>
            merge_o == {$past(operand_i[W-1:LOW_W]), $past(acc_o[LOW_W-1:0])}
            && $stable(acc_o));

    p_dip_merge_r10: assert property (@(posedge clk) disable iff (!rst_n)
        start_i && opcode_i == 6'o30 |=>
            merge_o == {$past(acc_o[W-1:LOW_W]), $past(operand_i[LOW_W-1:0])}
            && $stable(acc_o));

    always_comb begin
        if (!rst_n) begin
            a_reset_quiet_r1: assert (!done_o && !ovf_o && !skip_o);
        end
    end

endmodule

bind ocacc_alu ocacc_alu_chk #(.W(ocacc_pkg::WORD_W), .LOW_W(ocacc_pkg::LOW_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .opcode_i  (opcode_i),
    .operand_i (operand_i),
    .ovf_clr_i (ovf_clr_i),
    .acc_o     (acc_o),
    .ovf_o     (ovf_o),
    .skip_o    (skip_o),
    .merge_o   (merge_o),
    .done_o    (done_o)
);

// File: tb/ocacc_alu_tb.sv
`timescale 1ns/1ps
module ocacc_alu_tb;

    typedef struct packed {
        logic [35:0] acc;
        logic        ovf;
        logic        skip;
        logic [35:0] merge;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [5:0]  opcode_i = '0;
    logic [35:0] operand_i = '0;
    logic        ovf_clr_i = 1'b0;
    logic [35:0] acc_o;
    logic        ovf_o;
    logic        skip_o;
    logic [35:0] merge_o;
    logic        done_o;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    exp_t  exp_q[$];
    string tag_q[$];

    logic [35:0] m_acc = '0;
    logic [35:0] m_merge = '0;
    logic        m_ovf = 1'b0;

    always #2 clk = ~clk;

    ocacc_alu u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_i),
        .opcode_i  (opcode_i),
        .operand_i (operand_i),
        .ovf_clr_i (ovf_clr_i),
        .acc_o     (acc_o),
        .ovf_o     (ovf_o),
        .skip_o    (skip_o),
        .merge_o   (merge_o),
        .done_o    (done_o)
    );

    function automatic logic [35:0] oc_sum(input logic [35:0] a, input logic [35:0] b,
                                           output logic ov);
        longint unsigned s;
        logic [35:0] r;
        s = {28'd0, a} + {28'd0, b};
        if (s >= 64'h10_0000_0000) s = s - 64'h10_0000_0000 + 64'd1;
        r  = s[35:0];
        ov = (a[35] == b[35]) && (r[35] != a[35]);
        return r;
    endfunction

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_op(input logic [5:0] opc, input logic [35:0] opd,
                         input logic clr, input string tag);
        exp_t e;
        logic ov;
        logic [35:0] r;
        ov = 1'b0;
        if (clr) m_ovf = 1'b0;
        e.skip = 1'b0;
        case (opc)
            6'o40: begin r = oc_sum(m_acc, opd, ov);  m_acc = r; end
            6'o42: begin r = oc_sum(m_acc, ~opd, ov); m_acc = r; end
            6'o02: m_acc = m_acc & opd;
            6'o04: m_acc = m_acc | opd;
            6'o06: m_acc = m_acc ^ opd;
            6'o20: m_acc = opd;
            6'o26: m_merge = {opd[35:18], m_acc[17:0]};
            6'o30: m_merge = {m_acc[35:18], opd[17:0]};
            6'o50: e.skip = (m_acc != opd);
            default: ;
        endcase
        if (ov) m_ovf = 1'b1;
        e.acc = m_acc;
        e.ovf = m_ovf;
        e.merge = m_merge;
        exp_q.push_back(e);
        tag_q.push_back(tag);
        @(negedge clk);
        start_i = 1'b1;
        opcode_i = opc;
        operand_i = opd;
        ovf_clr_i = clr;
        @(negedge clk);
        start_i = 1'b0;
        ovf_clr_i = 1'b0;
        operand_i = '0;
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && done_o) begin
            if (exp_q.size() == 0) begin
                checks++;
                errors++;
                $display("FAIL R2 unexpected done actual=1 expected=0");
            end else begin
                exp_t e;
                exp_t a;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                a.acc = acc_o;
                a.ovf = ovf_o;
                a.skip = skip_o;
                a.merge = merge_o;
                checks++;
                if (a !== e) begin
                    errors++;
                    $display("FAIL %s actual acc=%h ovf=%b skip=%b merge=%h expected acc=%h ovf=%b skip=%b merge=%h",
                             t, a.acc, a.ovf, a.skip, a.merge, e.acc, e.ovf, e.skip, e.merge);
                end
            end
        end
    end

    initial begin
        #(4 * 20000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset outputs", {26'd0, done_o, ovf_o, skip_o, acc_o[35:0]}, 64'd0);
        check("R1 reset merge", {28'd0, merge_o}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release", {27'd0, done_o, acc_o}, 64'd0);

        do_op(6'o20, 36'd5, 1'b0, "R7 load 5");
        do_op(6'o40, 36'd3, 1'b0, "R3 add 3");
        do_op(6'o40, ~36'd3, 1'b0, "R3 add -3 end-around carry");
        do_op(6'o40, ~36'd3, 1'b0, "R3 add -3 again");
        do_op(6'o42, 36'd2, 1'b0, "R4 subtract 2");
        do_op(6'o42, 36'd0, 1'b0, "R4 subtract zero");
        do_op(6'o20, 36'd9, 1'b0, "R7 load 9");
        do_op(6'o42, 36'd9, 1'b0, "R4 equal subtract gives negative zero");
        check("R4 negative zero literal", {28'd0, m_acc}, {28'd0, 36'hF_FFFF_FFFF});

        // positive overflow
        do_op(6'o20, 36'h7_FFFF_FFFF, 1'b0, "R7 load max");
        do_op(6'o40, 36'd1, 1'b0, "R5 positive overflow");
        do_op(6'o20, 36'd7, 1'b0, "R5 overflow sticky across load");
        do_op(6'o04, 36'd8, 1'b0, "R6 ior keeps overflow");
        // clear alone
        @(negedge clk);
        ovf_clr_i = 1'b1;
        @(negedge clk);
        ovf_clr_i = 1'b0;
        m_ovf = 1'b0;
        check("R5 clear", {63'd0, ovf_o}, 64'd0);
        check("R2 no done on clear-only cycle", {63'd0, done_o}, 64'd0);
        check("R2 acc held when idle", {28'd0, acc_o}, {28'd0, m_acc});

        // negative overflow via subtract, with simultaneous clear
        do_op(6'o20, 36'h8_0000_0000, 1'b0, "R7 load most negative");
        do_op(6'o42, 36'd1, 1'b1, "R5 negative overflow wins over clear");
        do_op(6'o40, 36'd0, 1'b1, "R5 clear during non-overflow add");

        // logic
        do_op(6'o20, 36'hA_5A5A_F00F, 1'b0, "R7 load pattern");
        do_op(6'o02, 36'hF_0FF0_FF00, 1'b0, "R6 and");
        do_op(6'o06, 36'h3_3333_3333, 1'b0, "R6 xor");
        do_op(6'o04, 36'h0_0000_0FFF, 1'b0, "R6 ior");

        // skip
        do_op(6'o20, 36'h1_2345_6789, 1'b0, "R7 load for compare");
        do_op(6'o50, 36'h1_2345_6789, 1'b0, "R8 equal no skip");
        do_op(6'o50, 36'h1_2345_6788, 1'b0, "R8 differ skip");
        do_op(6'o40, 36'd0, 1'b0, "R8 skip cleared by add");
        do_op(6'o20, 36'd0, 1'b0, "R7 load +0");
        do_op(6'o50, 36'hF_FFFF_FFFF, 1'b0, "R8 +0 vs -0 skip");

        // partial stores
        do_op(6'o20, 36'hA_AAAA_5555, 1'b0, "R7 load for merge");
        do_op(6'o26, 36'h1_2345_6789, 1'b0, "R9 address part merge");
        do_op(6'o30, 36'h1_2345_6789, 1'b0, "R10 instruction part merge");

        // unused opcode
        do_op(6'o20, 36'h7_0000_0001, 1'b0, "R7 overflow setup load");
        do_op(6'o40, 36'h7_0000_0000, 1'b0, "R5 overflow before unused op");
        do_op(6'o50, 36'd1, 1'b0, "R8 skip before unused op");
        do_op(6'o77, 36'hF_FFFF_FFFF, 1'b0, "R11 unused opcode no effect");
        do_op(6'o12, 36'h0_0000_0001, 1'b0, "R11 second unused opcode");

        repeat (3) @(negedge clk);
        check("R2 all results seen", {32'd0, exp_q.size()}, 64'd0);
        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule